// File: doc/BRIEF.md
# Boot-Configured Address Decoder

This block sits on a processor bus and sorts each 24-bit byte address into one of six regions: on-chip dual-access RAM, one of four external chip-enable spaces, or on-chip ROM. For the chosen region it raises a one-hot select and returns the address relative to that region's base. The ROM window at the top of the map is present only while a ROM-disable bit is clear. When that bit is set, the same addresses fall through to the last external space. The bit is loaded from three boot-mode pins while hardware reset is held. Software may rewrite it at any later time, and a software reset leaves it unchanged.

A request is a level on `req_valid` with a stable address, and it completes on the cycle in which `ready` is high. RAM and external requests complete in their first cycle. ROM requests are paced by a small state machine with three states. `S_IDLE` is the resting state. On a ROM request it takes the transition `start_first` into `S_WAIT`, or the transition `start_seq` straight into `S_LAST`. From `S_WAIT` the machine takes `count` while cycles remain and `expire` into `S_LAST`. `S_LAST` raises `ready` and takes `finish` back to `S_IDLE`. A software reset takes `abort` from any state to `S_IDLE`. The first word of a ROM sequence takes four cycles and each following word takes two.

Top module: `boot_addr_decoder`

## Requirements
- R1: Addresses 000000h to 00FFFFh select the RAM region (sel bit 0), and the offset equals the address.
- R2: Addresses 010000h to 3FFFFFh, 400000h to 7FFFFFh, 800000h to BFFFFFh and C00000h to FFFFFFh select external spaces 0 to 3 (sel bits 1 to 4), with offsets measured from 010000h, 400000h, 800000h and C00000h. An exception is R3.
- R3: While `rom_dis` is 0, addresses FF8000h to FFFFFFh select ROM (sel bit 5) with offset address minus FF8000h. While `rom_dis` is 1, they select external space 3.
- R4: While `rst_n` is low, `rom_dis` takes 1 if `boot_mode` is 000b or 100b and 0 for the six other values. The pins are not sampled again after reset is released.
- R5: A one-cycle `soft_rst` pulse leaves `rom_dis` unchanged. It also ends any ROM sequence, so the next ROM access counts as a first word.
- R6: A cycle with `cfg_wr` high loads `cfg_wdata` into `rom_dis`, and the new value is visible from the following cycle.
- R7: A RAM or external request gets `ready` in its first cycle.
- R8: A ROM request that is a first word gets `ready` in its fourth cycle.
- R9: A ROM request at the previous completed ROM address plus 2 gets `ready` in its second cycle. This holds only if no RAM or external request, software reset or hardware reset came in between.
- R10: While `req_valid` is high exactly one sel bit is high, and none is high otherwise. The asserted select holds steady until `ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| soft_rst | input | 1 | Software reset pulse; ends a ROM sequence |
| boot_mode | input | 3 | Boot-mode pins, captured while rst_n is low |
| cfg_wr | input | 1 | Software write strobe for the ROM-disable bit |
| cfg_wdata | input | 1 | Value written into the ROM-disable bit |
| rom_dis | output | 1 | Current ROM-disable bit |
| req_valid | input | 1 | Bus request present |
| req_addr | input | 24 | Byte address of the request |
| ready | output | 1 | Request completes this cycle |
| sel | output | 6 | One-hot region: 0 RAM, 1-4 external 0-3, 5 ROM |
| offset | output | 24 | Address relative to the selected region base |

## Verification
The assertions assume that a master holds `req_addr` steady from the first cycle of a request until `ready`. They also assume that `cfg_wr` and `soft_rst` arrive only while no request is pending, and that `boot_mode` is steady around the release of reset. The bench drives each request from one falling edge and keeps it up until `ready` is seen. It issues configuration writes and software resets only in idle gaps between requests. It changes the boot pins only while reset is held low.

// File: rtl/boot_dec_pkg.sv
package boot_dec_pkg;

    typedef enum logic [2:0] {
        RG_RAM  = 3'd0,
        RG_EXT0 = 3'd1,
        RG_EXT1 = 3'd2,
        RG_EXT2 = 3'd3,
        RG_EXT3 = 3'd4,
        RG_ROM  = 3'd5
    } region_e;

    localparam int NUM_REGIONS = 6;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_WAIT = 2'd1,
        S_LAST = 2'd2
    } wait_state_e;

endpackage

// File: rtl/region_map.sv
module region_map
    import boot_dec_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int RAM_BYTES = 65536,
    parameter int ROM_BYTES = 32768
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rom_dis,
    output region_e           region,
    output logic [ADDR_W-1:0] offset
);
    localparam logic [ADDR_W-1:0] QUARTER  = ADDR_W'(1) << (ADDR_W - 2);
    localparam logic [ADDR_W-1:0] RAM_TOP  = ADDR_W'(RAM_BYTES);
    localparam logic [ADDR_W-1:0] ROM_BASE = ADDR_W'(0) - ADDR_W'(ROM_BYTES);
    localparam logic [ADDR_W-1:0] EXT0_BASE = RAM_TOP;
    localparam logic [ADDR_W-1:0] EXT1_BASE = QUARTER;
    localparam logic [ADDR_W-1:0] EXT2_BASE = QUARTER << 1;
    localparam logic [ADDR_W-1:0] EXT3_BASE = QUARTER * 3;

    logic [1:0] quarter_idx;
    logic [ADDR_W-1:0] base;

    assign quarter_idx = addr[ADDR_W-1:ADDR_W-2];

    always_comb begin
        unique case (quarter_idx)
            2'd0: region = (addr < RAM_TOP) ? RG_RAM : RG_EXT0;
            2'd1: region = RG_EXT1;
            2'd2: region = RG_EXT2;
            default: region = (!rom_dis && addr >= ROM_BASE) ? RG_ROM : RG_EXT3;
        endcase
    end

    always_comb begin
        unique case (region)
            RG_RAM:  base = '0;
            RG_EXT0: base = EXT0_BASE;
            RG_EXT1: base = EXT1_BASE;
            RG_EXT2: base = EXT2_BASE;
            RG_EXT3: base = EXT3_BASE;
            default: base = ROM_BASE;
        endcase
    end

    assign offset = addr - base;

endmodule

// File: rtl/rom_cfg_reg.sv
module rom_cfg_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] boot_mode,
    input  logic       cfg_wr,
    input  logic       cfg_wdata,
    output logic       rom_dis
);
    logic boot_disables;

    // The two boot codes that keep the ROM out of the map share zero low bits.
    assign boot_disables = (boot_mode[1:0] == 2'b00);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rom_dis <= boot_disables;
        end else if (cfg_wr) begin
            rom_dis <= cfg_wdata;
        end
    end

endmodule

// File: rtl/rom_wait_fsm.sv
module rom_wait_fsm
    import boot_dec_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int FIRST_CYC  = 4,
    parameter int SEQ_CYC    = 2,
    parameter int WORD_BYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              req_valid,
    input  logic              is_rom,
    input  logic [ADDR_W-1:0] addr,
    input  logic              bus_ready,
    output logic              rom_ready
);
    localparam int CNT_W = $clog2(FIRST_CYC + 1);
    localparam logic [CNT_W-1:0] FIRST_LOAD = CNT_W'(FIRST_CYC - 2);
    localparam logic [CNT_W-1:0] SEQ_LOAD   = CNT_W'(SEQ_CYC - 2);

    wait_state_e state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic [ADDR_W-1:0] last_addr;
    logic              seq_live;
    logic              is_next_word;
    logic [CNT_W-1:0]  load_val;

    assign is_next_word = seq_live && (addr == last_addr + ADDR_W'(WORD_BYTES));
    assign load_val     = is_next_word ? SEQ_LOAD : FIRST_LOAD;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // Next state and outputs
    always_comb begin
        state_nx  = state;
        cnt_nx    = cnt;
        rom_ready = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (req_valid && is_rom) begin
                    cnt_nx   = load_val;
                    state_nx = (load_val == '0) ? S_LAST : S_WAIT;
                end
            end
            S_WAIT: begin
                if (cnt == CNT_W'(1)) begin
                    state_nx = S_LAST;
                end
                cnt_nx = cnt - CNT_W'(1);
            end
            S_LAST: begin
                rom_ready = 1'b1;
                state_nx  = S_IDLE;
            end
            default: state_nx = S_IDLE;
        endcase
        if (soft_rst) begin
            state_nx = S_IDLE;
            cnt_nx   = '0;
        end
    end

    // Sequence tracker
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_addr <= '0;
            seq_live  <= 1'b0;
        end else if (soft_rst) begin
            seq_live <= 1'b0;
        end else if (req_valid && bus_ready) begin
            if (is_rom) begin
                last_addr <= addr;
                seq_live  <= 1'b1;
            end else begin
                seq_live <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/boot_addr_decoder.sv
module boot_addr_decoder
    import boot_dec_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int RAM_BYTES  = 65536,
    parameter int ROM_BYTES  = 32768,
    parameter int FIRST_CYC  = 4,
    parameter int SEQ_CYC    = 2,
    parameter int WORD_BYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [2:0]        boot_mode,
    input  logic              cfg_wr,
    input  logic              cfg_wdata,
    output logic              rom_dis,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              ready,
    output logic [NUM_REGIONS-1:0] sel,
    output logic [ADDR_W-1:0] offset
);
    region_e region;
    logic    is_rom;
    logic    rom_ready;

    rom_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .boot_mode (boot_mode),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .rom_dis   (rom_dis)
    );

    region_map #(
        .ADDR_W    (ADDR_W),
        .RAM_BYTES (RAM_BYTES),
        .ROM_BYTES (ROM_BYTES)
    ) u_map (
        .addr    (req_addr),
        .rom_dis (rom_dis),
        .region  (region),
        .offset  (offset)
    );

    assign is_rom = (region == RG_ROM);

    rom_wait_fsm #(
        .ADDR_W     (ADDR_W),
        .FIRST_CYC  (FIRST_CYC),
        .SEQ_CYC    (SEQ_CYC),
        .WORD_BYTES (WORD_BYTES)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .req_valid (req_valid),
        .is_rom    (is_rom),
        .addr      (req_addr),
        .bus_ready (ready),
        .rom_ready (rom_ready)
    );

    assign ready = req_valid && (is_rom ? rom_ready : 1'b1);

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_sel
        assign sel[g] = req_valid && (region == region_e'(g));
    end

endmodule

// File: rtl/boot_addr_decoder_chk.sv
module boot_addr_decoder_chk #(
    parameter int ADDR_W  = 24,
    parameter int NREG    = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst,
    input logic [2:0]        boot_mode,
    input logic              cfg_wr,
    input logic              cfg_wdata,
    input logic              rom_dis,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              ready,
    input logic [NREG-1:0]   sel,
    input logic [ADDR_W-1:0] offset
);
    localparam int ROM_BIT = NREG - 1;

    a_r10_onehot_sel: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $countones(sel) == 1);

    a_r10_no_sel_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> sel == '0);

    a_r10_sel_held: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ready && !cfg_wr) |=> $stable(sel));

    a_r3_rom_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        sel[ROM_BIT] |-> !rom_dis);

    a_r4_boot_capture: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> rom_dis == (boot_mode[1:0] == 2'b00));

    a_r5_soft_keeps_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && !cfg_wr) |=> $stable(rom_dis));

    a_r6_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> rom_dis == $past(cfg_wdata));

    a_r7_non_rom_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !sel[ROM_BIT]) |-> ready);

    a_r8_rom_not_first_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && sel[ROM_BIT]) |-> ($past(req_valid) && !$past(ready)));

    a_r1_ram_offset: assert property (@(posedge clk) disable iff (!rst_n)
        sel[0] |-> offset == req_addr);

endmodule

bind boot_addr_decoder boot_addr_decoder_chk #(
    .ADDR_W (ADDR_W),
    .NREG   (boot_dec_pkg::NUM_REGIONS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .boot_mode (boot_mode),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .rom_dis   (rom_dis),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .ready     (ready),
    .sel       (sel),
    .offset    (offset)
);

// File: tb/boot_addr_decoder_test.sv
module boot_addr_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic [2:0]  boot_mode = 3'b000;
    logic        cfg_wr = 1'b0;
    logic        cfg_wdata = 1'b0;
    logic        rom_dis;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic        ready;
    logic [5:0]  sel;
    logic [23:0] offset;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // model state
    bit          m_dis;
    bit          m_seq;
    logic [23:0] m_last;

    always #4 clk = ~clk;

    boot_addr_decoder uut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .boot_mode(boot_mode),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .rom_dis(rom_dis),
        .req_valid(req_valid), .req_addr(req_addr), .ready(ready),
        .sel(sel), .offset(offset)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_region(input logic [23:0] a, input bit dis);
        if (a < 24'h010000) return 0;
        if (a < 24'h400000) return 1;
        if (a < 24'h800000) return 2;
        if (a < 24'hC00000) return 3;
        if (!dis && a >= 24'hFF8000) return 5;
        return 4;
    endfunction

    function automatic logic [23:0] exp_base(input int r);
        case (r)
            0: return 24'h000000;
            1: return 24'h010000;
            2: return 24'h400000;
            3: return 24'h800000;
            4: return 24'hC00000;
            default: return 24'hFF8000;
        endcase
    endfunction

    function automatic int exp_cycles(input logic [23:0] a, input int r);
        if (r != 5) return 1;
        if (m_seq && a == m_last + 24'd2) return 2;
        return 4;
    endfunction

    task automatic access(input logic [23:0] a);
        int r, want, n;
        logic [5:0] first_sel;
        bit held;
        r = exp_region(a, m_dis);
        want = exp_cycles(a, r);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr = a;
        #1;
        n = 1;
        first_sel = sel;
        held = 1;
        while (!ready && n < 12) begin
            @(negedge clk);
            #1;
            n++;
            if (sel != first_sel) held = 0;
        end
        check(sel == (6'd1 << r), "R10_R1_R2_R3 sel", sel, 6'd1 << r);
        check(offset == a - exp_base(r), "R1_R2_R3 offset", offset, a - exp_base(r));
        check(held, "R10 sel held", sel, first_sel);
        if (r != 5)
            check(n == want, "R7 latency", n, want);
        else if (want == 4)
            check(n == want, "R8 latency", n, want);
        else
            check(n == want, "R9 latency", n, want);
        if (r == 5) begin
            m_seq = 1;
            m_last = a;
        end else begin
            m_seq = 0;
        end
    endtask

    task automatic go_idle();
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        check(sel == 6'd0, "R10 idle sel", sel, 0);
    endtask

    task automatic cfg_write(input bit v);
        @(negedge clk);
        req_valid = 1'b0;
        cfg_wr = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
        m_dis = v;
        check(rom_dis == v, "R6 cfg write", rom_dis, v);
    endtask

    task automatic pulse_soft();
        logic was;
        @(negedge clk);
        req_valid = 1'b0;
        was = rom_dis;
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        m_seq = 0;
        check(rom_dis == was, "R5 soft reset keeps bit", rom_dis, was);
    endtask

    task automatic hard_reset(input logic [2:0] bm);
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b0;
        boot_mode = bm;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        boot_mode = ~bm;
        @(negedge clk);
        m_dis = (bm == 3'b000 || bm == 3'b100);
        m_seq = 0;
        check(rom_dis == m_dis, "R4 boot capture", rom_dis, m_dis);
        check(sel == 6'd0 && ready == 1'b0, "R10 reset state", {ready, sel}, 0);
    endtask

    initial begin
        #(8 * 150000);
        $display("FAIL watchdog expired");
        failures++;
        checks++;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int seed;
        logic [23:0] a;
        seed = 32'h5EED_0042;
        void'($urandom(seed));
        m_seq = 0;
        m_last = '0;
        // R4 every boot code
        for (int bm = 0; bm < 8; bm++) hard_reset(3'(bm));
        hard_reset(3'b010);  // ROM enabled
        // R1 R2 boundaries
        access(24'h000000); access(24'h00FFFE); access(24'h010000);
        access(24'h3FFFFF); access(24'h400000); access(24'h7FFFFF);
        access(24'h800000); access(24'hBFFFFF); access(24'hC00000);
        access(24'hFF7FFE);
        // R3 R8 R9 ROM window and sequence
        access(24'hFF8000); access(24'hFF8002); access(24'hFF8004);
        access(24'hFF8008);                       // gap -> first word
        access(24'hFF800A);
        access(24'h001000); access(24'hFF800C);   // non-ROM between -> first word
        access(24'hFFFFFE);
        go_idle();
        access(24'h000000);                       // RAM after idle gap
        access(24'hFFFF00); go_idle(); access(24'hFFFF02); // idle keeps sequence
        // R5 soft reset ends sequence and keeps bit
        pulse_soft();
        access(24'hFFFF04);
        // R6 disable ROM, window goes to external space 3
        cfg_write(1'b1);
        access(24'hFF8000); access(24'hFFFFFF);
        pulse_soft();
        cfg_write(1'b0);
        access(24'hFF9000);
        // random mix
        for (int i = 0; i < 400; i++) begin
            int k;
            k = $urandom_range(0, 99);
            if (k < 30) a = m_last + 24'd2;
            else if (k < 55) a = 24'hFF8000 | 24'($urandom_range(0, 16383) * 2);
            else if (k < 65) a = 24'($urandom_range(0, 32767) * 2);
            else a = 24'($urandom);
            access(a);
            if (k % 17 == 0) go_idle();
            if (k % 23 == 0) cfg_write(1'($urandom_range(0, 1)));
            if (k % 29 == 0) pulse_soft();
        end
        go_idle();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule